// File: doc/BRIEF.md
# NAND Flash Bus Front End

This block is the device side of a parallel NAND-style flash bus. It samples the control strobes and the I/O bus on a system clock and finds the strobe edges. On a write-enable rising edge it routes the low I/O byte to the command register or the address registers, or writes a full-width data word into a small internal page buffer. The buffer stands in for the flash array. Each read-enable falling edge sends the word at the current column to the bus after a fixed access delay, then advances the column.

Three confirm commands start a busy period with its own length: read, program and erase. The ready/busy output is low for that period. Write protect and a lock-enable input together gate program and erase. Write protect also cancels a program or erase that is already running. The bus width is 8 or 16 bits. Commands and addresses always use the low byte.

Top module: `nand_bus_front`

## Requirements
- R1: After reset, rb is 1, io_oe is 0, cmd_q is 8'hFF, addr_q is 0 and every page-buffer word is 0.
- R2: A WE rising edge with CE low, CLE high and ALE low, while ready, loads io_in[7:0] into cmd_q. In 16-bit mode io_in[15:8] does not affect cmd_q.
- R3: A WE rising edge with ALE high and CLE low, while ready and selected, stores io_in[7:0] into the next byte of addr_q, starting at bits 7:0. The first address byte after a command also sets the column. Bytes after ADDR_BYTES are dropped. Any command restarts the byte index.
- R4: A WE rising edge with CLE and ALE both high changes neither cmd_q nor addr_q.
- R5: After command 8'h80, each WE rising edge with CLE and ALE low writes the full io_in word to the page buffer at the column, then increments the column modulo PAGE_WORDS.
- R6: Each RE falling edge with CE low, while ready, places the buffer word at the column on io_out on the (RD_LAT+2)-th rising clock edge after the pin falls, and increments the column.
- R7: io_oe is 1 only when CE and RE were both low at the previous clock edge. Otherwise the bus is released.
- R8: Command 8'h30 after 8'h00, 8'h10 after 8'h80 and 8'hD0 after 8'h60 drive rb low for T_READ, T_PROG and T_ERASE cycles. While rb is low, WE and RE edges are ignored.
- R9: Raising CE while rb is low does not end the busy period.
- R10: lock_en high with wp_n low sets a lock that stays set while lock_en remains high. lock_en low clears the lock and prevents it from being set.
- R11: A program or erase confirm given while wp_n is low or the lock is set is dropped, and rb stays 1.
- R12: wp_n low during a program or erase busy period ends it, and rb returns to 1. An erase cut short this way leaves the buffer unchanged.
- R13: When an erase completes, every page-buffer word becomes all ones.
- R14: WE edges with CE high change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| lock_en | input | 1 | Enables the block-lock mechanism |
| io_in | input | DW | I/O bus, input side |
| io_out | output | DW | I/O bus, output side |
| io_oe | output | 1 | Drive enable for io_out |
| rb | output | 1 | Ready (1) / busy (0) |
| cmd_q | output | 8 | Command register |
| addr_q | output | 8*ADDR_BYTES | Address bytes, first byte at bits 7:0 |

## Verification
The strobe decoder is driven with command cycles that carry junk on the upper byte and with address bursts longer than ADDR_BYTES. It also sees cycles with both CLE and ALE high and cycles with CE high. Together these separate correct byte routing from leakage of the upper byte, overflow of the address index and strobes that should be ignored. Data bursts that cross the last column, followed by reads from chosen columns, show both the column wrap and the read latency. Confirms are given with write protect low, with the lock held, with CE raised mid-operation and with write protect dropped mid-erase. Each one separates dropping, aborting and completing an operation.

// File: rtl/nand_bus_front.sv
module nand_bus_front #(
  parameter int DW         = 16,
  parameter int PAGE_WORDS = 16,
  parameter int ADDR_BYTES = 3,
  parameter int T_READ     = 20,
  parameter int T_PROG     = 40,
  parameter int T_ERASE    = 60,
  parameter int RD_LAT     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic                    cle,
  input  logic                    ale,
  input  logic                    we_n,
  input  logic                    re_n,
  input  logic                    wp_n,
  input  logic                    lock_en,
  input  logic [DW-1:0]           io_in,
  output logic [DW-1:0]           io_out,
  output logic                    io_oe,
  output logic                    rb,
  output logic [7:0]              cmd_q,
  output logic [ADDR_BYTES*8-1:0] addr_q
);
  localparam int CW   = $clog2(PAGE_WORDS);
  localparam int AIW  = $clog2(ADDR_BYTES + 1);
  localparam int TMAX = (T_ERASE > T_PROG) ? ((T_ERASE > T_READ) ? T_ERASE : T_READ)
                                           : ((T_PROG > T_READ) ? T_PROG : T_READ);
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [7:0] OP_RD_SETUP = 8'h00, OP_RD_GO = 8'h30;
  localparam logic [7:0] OP_PG_SETUP = 8'h80, OP_PG_GO = 8'h10;
  localparam logic [7:0] OP_ER_SETUP = 8'h60, OP_ER_GO = 8'hD0;
  localparam logic [1:0] K_READ = 2'd0, K_PROG = 2'd1, K_ERASE = 2'd2;

  logic          ce_s, cle_s, ale_s, we_s, re_s, wp_s, lock_s, we_q, re_q;
  logic [DW-1:0] io_s;
  logic          locked;
  logic [TW-1:0] busy_cnt;
  logic [1:0]    op_r;
  logic [CW-1:0] col;
  logic [AIW-1:0] aidx;
  logic [DW-1:0] pbuf [PAGE_WORDS];
  logic [DW-1:0] rd_d [RD_LAT];
  logic [RD_LAT-1:0] rd_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_s <= 1'b1; cle_s <= 1'b0; ale_s <= 1'b0; we_s <= 1'b1; re_s <= 1'b1;
      wp_s <= 1'b1; lock_s <= 1'b0; io_s <= '0; we_q <= 1'b1; re_q <= 1'b1;
    end else begin
      ce_s <= ce_n; cle_s <= cle; ale_s <= ale; we_s <= we_n; re_s <= re_n;
      wp_s <= wp_n; lock_s <= lock_en; io_s <= io_in; we_q <= we_s; re_q <= re_s;
    end
  end

  wire ready   = (busy_cnt == '0);
  wire we_rise = we_s & ~we_q & ~ce_s & ready;
  wire re_fall = ~re_s & re_q & ~ce_s & ready;
  wire cmd_ev  = we_rise & cle_s & ~ale_s;
  wire adr_ev  = we_rise & ale_s & ~cle_s;
  wire dat_ev  = we_rise & ~cle_s & ~ale_s & (cmd_q == OP_PG_SETUP);
  wire guard   = wp_s & ~locked;
  wire [7:0] lo = io_s[7:0];
  wire go_rd   = cmd_ev & (lo == OP_RD_GO) & (cmd_q == OP_RD_SETUP);
  wire go_pg   = cmd_ev & (lo == OP_PG_GO) & (cmd_q == OP_PG_SETUP) & guard;
  wire go_er   = cmd_ev & (lo == OP_ER_GO) & (cmd_q == OP_ER_SETUP) & guard;
  wire abort   = ~ready & (op_r != K_READ) & ~wp_s;
  wire fill    = ~abort & (busy_cnt == TW'(1)) & (op_r == K_ERASE);

  assign rb    = ready;
  assign io_oe = ~ce_s & ~re_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 locked <= 1'b0;
    else if (lock_s && !wp_s)   locked <= 1'b1;
    else if (!lock_s)           locked <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0; op_r <= K_READ;
    end else if (abort) busy_cnt <= '0;
    else if (go_rd) begin busy_cnt <= TW'(T_READ);  op_r <= K_READ;  end
    else if (go_pg) begin busy_cnt <= TW'(T_PROG);  op_r <= K_PROG;  end
    else if (go_er) begin busy_cnt <= TW'(T_ERASE); op_r <= K_ERASE; end
    else if (!ready) busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 8'hFF; addr_q <= '0; aidx <= '0; col <= '0;
    end else begin
      if (cmd_ev) begin
        cmd_q <= lo;
        aidx  <= '0;
      end
      if (adr_ev && aidx < AIW'(ADDR_BYTES)) begin
        addr_q[aidx*8 +: 8] <= lo;
        aidx <= aidx + 1'b1;
      end
      if (adr_ev && aidx == '0) col <= lo[CW-1:0];
      else if (dat_ev || re_fall) col <= col + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= '0;
    end else if (fill) begin
      for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= '1;
    end else if (dat_ev) pbuf[col] <= io_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v <= '0; io_out <= '0;
      for (int i = 0; i < RD_LAT; i++) rd_d[i] <= '0;
    end else begin
      rd_v[0] <= re_fall;
      rd_d[0] <= pbuf[col];
      for (int i = 1; i < RD_LAT; i++) begin
        rd_v[i] <= rd_v[i-1];
        rd_d[i] <= rd_d[i-1];
      end
      if (rd_v[RD_LAT-1]) io_out <= rd_d[RD_LAT-1];
    end
  end
endmodule

// File: rtl/nand_bus_front_chk.sv
module nand_bus_front_chk #(parameter int AW = 24) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          cle,
  input logic          ale,
  input logic          we_n,
  input logic          re_n,
  input logic [7:0]    io_lo,
  input logic          io_oe,
  input logic          rb,
  input logic [7:0]    cmd_q,
  input logic [AW-1:0] addr_q
);
  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (!$past(ce_n) && !$past(re_n))); // R7
  AST_CMD_FROM_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_q) |-> (cmd_q == $past(io_lo, 2) && $past(cle, 2) && !$past(ale, 2))); // R2
  AST_CMD_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_q) |-> (!$past(ce_n, 2) && $past(we_n, 2) && !$past(we_n, 3))); // R14
  AST_ADDR_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> ($past(ale, 2) && !$past(cle, 2))); // R4
  AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> $past(rb)); // R8
  AST_BUSY_FROM_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb) |-> ($past(cle, 2) && $past(we_n, 2) && !$past(we_n, 3))); // R8
endmodule

bind nand_bus_front nand_bus_front_chk #(.AW(ADDR_BYTES*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
  .re_n(re_n), .io_lo(io_in[7:0]), .io_oe(io_oe), .rb(rb), .cmd_q(cmd_q),
  .addr_q(addr_q)
);

// File: tb/tb_nand_bus_front.sv
module tb_nand_bus_front;
  localparam int DW = 16, PW = 16, AB = 3, TR = 8, TP = 12, TE = 16, RL = 2;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, cle = 0, ale = 0, we_n = 1, re_n = 1, wp_n = 1, lock_en = 0;
  logic [DW-1:0] io_in = '0;
  logic [DW-1:0] io_out;
  logic io_oe, rb;
  logic [7:0] cmd_q;
  logic [AB*8-1:0] addr_q;

  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  nand_bus_front #(.DW(DW), .PAGE_WORDS(PW), .ADDR_BYTES(AB), .T_READ(TR),
    .T_PROG(TP), .T_ERASE(TE), .RD_LAT(RL)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .lock_en(lock_en), .io_in(io_in), .io_out(io_out),
    .io_oe(io_oe), .rb(rb), .cmd_q(cmd_q), .addr_q(addr_q));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_op, m_col, m_aidx, m_edge;
  bit m_lock;
  logic [7:0] m_cmd;
  logic [AB*8-1:0] m_addr;
  logic [DW-1:0] m_buf [PW];
  logic [DW-1:0] m_io;
  int q_due[$];
  logic [DW-1:0] q_dat[$];
  bit s_ce, s_cle, s_ale, s_we, s_re, s_wp, s_lk, p_we, p_re;
  logic [DW-1:0] s_io;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_op = 0; m_col = 0; m_aidx = 0; m_edge = 0; m_lock = 0;
      m_cmd = 8'hFF; m_addr = '0; m_io = '0;
      foreach (m_buf[i]) m_buf[i] = '0;
      q_due.delete(); q_dat.delete();
      s_ce = 1; s_cle = 0; s_ale = 0; s_we = 1; s_re = 1; s_wp = 1; s_lk = 0;
      p_we = 1; p_re = 1; s_io = '0;
    end else begin
      bit rdy, wr, rf, ab, fl, ok;
      logic [7:0] b;
      m_edge++;
      rdy = (m_cnt == 0);
      wr = s_we && !p_we && !s_ce && rdy;
      rf = !s_re && p_re && !s_ce && rdy;
      ab = !rdy && m_op != 0 && !s_wp;
      fl = !ab && m_cnt == 1 && m_op == 2;
      ok = s_wp && !m_lock;
      b = s_io[7:0];
      if (q_due.size() > 0 && q_due[0] == m_edge) begin
        m_io = q_dat.pop_front(); void'(q_due.pop_front());
      end
      if (rf) begin
        q_due.push_back(m_edge + RL); q_dat.push_back(m_buf[m_col]);
        m_col = (m_col + 1) % PW;
      end
      if (ab) m_cnt = 0;
      else if (m_cnt > 0) m_cnt--;
      if (fl) foreach (m_buf[i]) m_buf[i] = '1;
      if (wr && s_cle && !s_ale) begin
        if (b == 8'h30 && m_cmd == 8'h00) begin m_cnt = TR; m_op = 0; end
        if (b == 8'h10 && m_cmd == 8'h80 && ok) begin m_cnt = TP; m_op = 1; end
        if (b == 8'hD0 && m_cmd == 8'h60 && ok) begin m_cnt = TE; m_op = 2; end
        m_cmd = b; m_aidx = 0;
      end else if (wr && s_ale && !s_cle) begin
        if (m_aidx == 0) m_col = b % PW;
        if (m_aidx < AB) begin m_addr[m_aidx*8 +: 8] = b; m_aidx++; end
      end else if (wr && !s_cle && !s_ale && m_cmd == 8'h80) begin
        m_buf[m_col] = s_io; m_col = (m_col + 1) % PW;
      end
      if (s_lk && !s_wp) m_lock = 1; else if (!s_lk) m_lock = 0;
      p_we = s_we; p_re = s_re;
      s_ce = ce_n; s_cle = cle; s_ale = ale; s_we = we_n; s_re = re_n;
      s_wp = wp_n; s_lk = lock_en; s_io = io_in;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R8 rb vs model", rb, m_cnt == 0);
    chk("R7 io_oe vs model", io_oe, !s_ce && !s_re);
    if (io_oe) chk("R6 io_out vs model", io_out, m_io);
    chk("R2 cmd_q vs model", cmd_q, m_cmd);
    chk("R3 addr_q vs model", addr_q, m_addr);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic strobe(bit c, bit a, logic [DW-1:0] v);
    @(negedge clk); cle = c; ale = a; io_in = v;
    repeat (2) @(negedge clk); we_n = 0;
    repeat (2) @(negedge clk); we_n = 1;
    repeat (2) @(negedge clk); cle = 0; ale = 0;
  endtask
  task automatic cmd(logic [DW-1:0] v); strobe(1, 0, v); endtask
  task automatic adr(logic [7:0] v); strobe(0, 1, {{(DW-8){1'b1}}, v}); endtask
  task automatic wdat(logic [DW-1:0] v); strobe(0, 0, v); endtask
  task automatic wait_ready();
    for (int i = 0; i < 200 && !rb; i++) @(negedge clk);
    @(negedge clk);
  endtask
  task automatic rd(string req, logic [DW-1:0] exp);
    @(negedge clk); re_n = 0;
    repeat (RL + 3) @(negedge clk);
    chk(req, io_oe, 1);
    chk(req, io_out, exp);
    re_n = 1;
    repeat (2) @(negedge clk);
  endtask
  task automatic open_read(logic [7:0] c);
    cmd(16'h0000); adr(c); cmd(16'h0030); wait_ready();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rb", rb, 1); chk("R1 io_oe", io_oe, 0);
    chk("R1 cmd_q", cmd_q, 8'hFF); chk("R1 addr_q", addr_q, 0);
    ce_n = 0;
    cmd(16'hA580);
    chk("R2 low byte only", cmd_q, 8'h80);
    adr(8'h03); adr(8'h12); adr(8'h34); adr(8'h77);
    chk("R3 three bytes kept", addr_q, 24'h341203);
    strobe(1, 1, 16'h0055);
    chk("R4 cmd unchanged", cmd_q, 8'h80); chk("R4 addr unchanged", addr_q, 24'h341203);
    ce_n = 1; cmd(16'h0060); ce_n = 0;
    chk("R14 deselected WE", cmd_q, 8'h80);
    wdat(16'hBEEF); wdat(16'h1234);
    cmd(16'h0010);
    chk("R8 program busy", rb, 0);
    cmd(16'h0000);
    chk("R8 command ignored while busy", cmd_q, 8'h10);
    wait_ready();
    chk("R8 program done", rb, 1);
    open_read(8'h03);
    rd("R6 first word", 16'hBEEF); rd("R5 second word", 16'h1234); rd("R6 next column", 16'h0000);
    chk("R7 idle bus", io_oe, 0);
    ce_n = 1; re_n = 0; repeat (3) @(negedge clk);
    chk("R7 deselected read", io_oe, 0);
    re_n = 1; ce_n = 0; repeat (2) @(negedge clk);
    cmd(16'h0080); adr(8'h0F); wdat(16'hAAAA); wdat(16'h5555); cmd(16'h0010);
    ce_n = 1; repeat (4) @(negedge clk);
    chk("R9 busy after deselect", rb, 0);
    wait_ready();
    chk("R9 completes while deselected", rb, 1);
    ce_n = 0;
    open_read(8'h0F);
    rd("R5 last column", 16'hAAAA); rd("R5 column wrap", 16'h5555);
    wp_n = 0; repeat (2) @(negedge clk);
    cmd(16'h0080); adr(8'h00); cmd(16'h0010);
    chk("R11 protected program dropped", rb, 1);
    wp_n = 1;
    lock_en = 1; wp_n = 0; repeat (3) @(negedge clk); wp_n = 1; repeat (3) @(negedge clk);
    cmd(16'h0080); cmd(16'h0010);
    chk("R10 lock persists", rb, 1);
    lock_en = 0; repeat (3) @(negedge clk);
    cmd(16'h0080); cmd(16'h0010);
    chk("R10 lock cleared", rb, 0);
    wait_ready();
    cmd(16'h0060); adr(8'h00); cmd(16'h00D0);
    chk("R8 erase busy", rb, 0);
    repeat (3) @(negedge clk); wp_n = 0; repeat (3) @(negedge clk);
    chk("R12 abort", rb, 1);
    wp_n = 1;
    open_read(8'h00);
    rd("R12 buffer kept", 16'h5555);
    cmd(16'h0060); adr(8'h00); cmd(16'h00D0); wait_ready();
    open_read(8'h0F);
    rd("R13 erased", 16'hFFFF); rd("R13 erased wrap", 16'hFFFF);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule